// File: doc/BRIEF.md
# Spike-Timing Half Adder

This block adds two one-bit operands whose values are carried by when a single-cycle pulse arrives, not by a level. Each operand line delivers exactly one pulse per evaluation round, called a token. A pulse that lands inside a short window after the token starts means 1. A pulse that lands after that window means 0. The token starts on the first cycle in which either operand line pulses. That cycle is offset 0, and every other time in the token is counted from it.

Each of the two result lines, sum and carry, produces exactly one pulse per token. A line that has a 1 to report pulses early, in the cycle right after the coincidence window closes. A line that reports 0 pulses at the fixed late offset. A guard gap keeps the early slot apart from the late slot. When a token closes, the block pulses a fault line if the token was broken: an operand never arrived, or an operand pulsed twice. The block is used wherever a timing-coded stage needs arithmetic. No request or acknowledge wires are needed, because the first arrival opens the token and the result pulses end it.

Top module: `spk_half_adder`

## Requirements
- R1: During reset and after it, with no input pulses, `sum_spk_o`, `carry_spk_o` and `fault_o` stay low.
- R2: The first cycle in which `op_a_i` or `op_b_i` is high is token offset 0. If both are high in that cycle, both operands count as early (value 1).
- R3: An operand pulse at offsets 0 to WC-1 is early (1). If both operands are early, `carry_spk_o` pulses at offset WC and `sum_spk_o` pulses at offset DELTA.
- R4: If exactly one operand is early, `sum_spk_o` pulses at offset WC and `carry_spk_o` pulses at offset DELTA.
- R5: An operand pulse at any offset from WC through DELTA counts as late (0). This includes pulses in the guard gap, offsets WC to WC+GUARD-1.
- R6: Each result line pulses exactly once per token, for one cycle. A line that fired early does not fire at offset DELTA.
- R7: A second pulse on the same operand within one token does not change either result line. It causes a one-cycle `fault_o` pulse at offset DELTA+1.
- R8: If an operand has not pulsed by offset DELTA, `fault_o` pulses for one cycle at offset DELTA+1. The result lines still pulse as R3 and R4 state, with the missing operand treated as 0.
- R9: A token covers offsets 0 to DELTA. A pulse at offset DELTA+1 or later opens a new token.
- R10: The parameters must satisfy WC + GUARD < DELTA, and this is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 1 | Operand A pulse line |
| op_b_i | input | 1 | Operand B pulse line |
| sum_spk_o | output | 1 | Sum pulse: offset WC means 1, offset DELTA means 0 |
| carry_spk_o | output | 1 | Carry pulse: offset WC means 1, offset DELTA means 0 |
| fault_o | output | 1 | One-cycle pulse at offset DELTA+1 when a token was broken |

## Verification
The bench builds the block with WC=3, GUARD=2 and DELTA=9. This gives two guard offsets (3 and 4) and several late offsets (5 to 9), so a pulse on the last early offset, on the first guard offset and on offset DELTA itself can each be placed apart from the others. The window is three cycles wide, so a staggered pair of early pulses and a duplicate pulse inside the window are both reachable. A token of ten offsets is short enough to run a second token directly at offset DELTA+1.

// File: rtl/spk_ha_pkg.sv
package spk_ha_pkg;

    typedef enum logic {
        TK_IDLE = 1'b0,
        TK_RUN  = 1'b1
    } tok_state_e;

    // per-operand bookkeeping inside one token
    typedef struct packed {
        logic seen;
        logic early;
        logic dup;
    } arr_state_t;

    // per-result-line state inside one token
    typedef struct packed {
        logic fired;
        logic spk;
    } line_state_t;

endpackage

// File: rtl/spk_arrival.sv
module spk_arrival
    import spk_ha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spike_i,
    input  logic win_open_i,
    input  logic close_i,
    output logic early_o,
    output logic seen_o,
    output logic dup_o
);

    arr_state_t st_d, st_q;
    logic       early_now, seen_now, dup_now;

    always_comb begin
        // a repeated pulse never upgrades the operand to early
        early_now = st_q.early | (spike_i & win_open_i & ~st_q.seen);
        seen_now  = st_q.seen | spike_i;
        dup_now   = st_q.dup | (spike_i & st_q.seen);
        st_d      = st_q;
        if (close_i) begin
            st_d = '0;
        end else begin
            st_d.seen  = seen_now;
            st_d.early = early_now;
            st_d.dup   = dup_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign early_o = early_now;
    assign seen_o  = seen_now;
    assign dup_o   = dup_now;

    AST_DUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (spike_i && st_q.seen && !close_i) |=> (st_q.early == $past(st_q.early))); // R7

endmodule

// File: rtl/spk_line.sv
module spk_line
    import spk_ha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic early_fire_i,
    input  logic late_due_i,
    input  logic close_i,
    output logic spk_o
);

    line_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.spk = early_fire_i | (late_due_i & ~st_q.fired);
        if (close_i) st_d.fired = 1'b0;
        else         st_d.fired = st_q.fired | early_fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spk_o = st_q.spk;

    AST_LATE_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
        (late_due_i && st_q.fired) |=> !spk_o); // R6

    AST_SINGLE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        early_fire_i |-> !st_q.fired); // R6

endmodule

// File: rtl/spk_half_adder.sv
module spk_half_adder
    import spk_ha_pkg::*;
#(
    parameter int WC    = 3,
    parameter int GUARD = 2,
    parameter int DELTA = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_a_i,
    input  logic op_b_i,
    output logic sum_spk_o,
    output logic carry_spk_o,
    output logic fault_o
);

    localparam int NOPS = 2;
    localparam int OW   = $clog2(DELTA + 2);
    localparam logic [OW-1:0] OFF_DECIDE = OW'(WC - 1);
    localparam logic [OW-1:0] OFF_EARLY  = OW'(WC);
    localparam logic [OW-1:0] OFF_LATE_M = OW'(DELTA - 1);
    localparam logic [OW-1:0] OFF_LAST   = OW'(DELTA);

    if (WC < 1 || GUARD < 0 || WC + GUARD >= DELTA) begin : g_bad_timing
        $error("spk_half_adder: need WC >= 1 and WC + GUARD < DELTA");
    end

    initial begin
        AST_PARAM_ORDER: assert (WC + GUARD < DELTA); // R10
    end

    typedef struct packed {
        tok_state_e     st;
        logic [OW-1:0]  off;
        logic           fault;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NOPS-1:0] spk_in, early_v, seen_v, dup_v;
    logic [OW-1:0]   off_now;
    logic            tok_live, win_open, decide, late_due, close;
    logic            both_early, one_early;
    logic            sum_early, carry_early;

    assign spk_in = {op_b_i, op_a_i};

    always_comb begin
        off_now  = (seq_q.st == TK_RUN) ? seq_q.off : '0;
        tok_live = (seq_q.st == TK_RUN) | (|spk_in);
        win_open = off_now < OFF_EARLY;
        decide   = tok_live && (off_now == OFF_DECIDE);
        late_due = tok_live && (off_now == OFF_LATE_M);
        close    = tok_live && (off_now == OFF_LAST);
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        spk_arrival u_arr (
            .clk        (clk),
            .rst_n      (rst_n),
            .spike_i    (spk_in[i]),
            .win_open_i (win_open),
            .close_i    (close),
            .early_o    (early_v[i]),
            .seen_o     (seen_v[i]),
            .dup_o      (dup_v[i])
        );
    end

    always_comb begin
        both_early  = &early_v;
        one_early   = ^early_v;
        carry_early = decide & both_early;
        sum_early   = decide & one_early;
    end

    spk_line u_sum (
        .clk          (clk),
        .rst_n        (rst_n),
        .early_fire_i (sum_early),
        .late_due_i   (late_due),
        .close_i      (close),
        .spk_o        (sum_spk_o)
    );

    spk_line u_carry (
        .clk          (clk),
        .rst_n        (rst_n),
        .early_fire_i (carry_early),
        .late_due_i   (late_due),
        .close_i      (close),
        .spk_o        (carry_spk_o)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.fault = close & (~(&seen_v) | (|dup_v));
        if (tok_live && !close) begin
            seq_d.st  = TK_RUN;
            seq_d.off = off_now + 1'b1;
        end else begin
            seq_d.st  = TK_IDLE;
            seq_d.off = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= TK_IDLE;
            seq_q.off   <= '0;
            seq_q.fault <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fault_o = seq_q.fault;

    AST_OUT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_spk_o || carry_spk_o) |-> (seq_q.st == TK_RUN &&
            (seq_q.off == OFF_EARLY || seq_q.off == OFF_LAST))); // R3

    AST_EARLY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == TK_RUN && seq_q.off == OFF_EARLY) |-> !(sum_spk_o && carry_spk_o)); // R4

    AST_FAULT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (seq_q.st == TK_IDLE && $past(seq_q.off) == OFF_LAST)); // R8

    AST_TOKEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == TK_RUN) |-> (seq_q.off <= OFF_LAST)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == TK_IDLE && !$past(seq_q.st == TK_RUN)) |-> !(sum_spk_o || carry_spk_o)); // R1

endmodule

// File: tb/tb_spk_half_adder.sv
module tb_spk_half_adder;

    localparam int WC    = 3;
    localparam int GUARD = 2;
    localparam int DELTA = 9;
    localparam int N     = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_a = 1'b0, op_b = 1'b0;
    logic sum_spk, carry_spk, fault;

    int total = 0;
    int fails = 0;

    logic a_sp [N];
    logic b_sp [N];
    logic s_out[N];
    logic c_out[N];
    logic f_out[N];

    always #2 clk = ~clk;  // 250 MHz

    spk_half_adder #(.WC(WC), .GUARD(GUARD), .DELTA(DELTA)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .sum_spk_o   (sum_spk),
        .carry_spk_o (carry_spk),
        .fault_o     (fault)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic pick(input int sel, input int k);
        if (sel == 0) return s_out[k];
        if (sel == 1) return c_out[k];
        return f_out[k];
    endfunction

    function automatic int first_hit(input int sel, input int lo, input int hi);
        for (int k = lo; k <= hi; k++) if (pick(sel, k)) return k;
        return -1;
    endfunction

    function automatic int n_hits(input int sel, input int lo, input int hi);
        int n = 0;
        for (int k = lo; k <= hi; k++) if (pick(sel, k)) n++;
        return n;
    endfunction

    task automatic clear_seq();
        for (int k = 0; k < N; k++) begin
            a_sp[k] = 1'b0; b_sp[k] = 1'b0;
            s_out[k] = 1'b0; c_out[k] = 1'b0; f_out[k] = 1'b0;
        end
    endtask

    // index k: inputs driven for cycle k, outputs seen during cycle k
    task automatic play(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_out[k] = sum_spk;
            c_out[k] = carry_spk;
            f_out[k] = fault;
            op_a = a_sp[k];
            op_b = b_sp[k];
        end
        @(negedge clk);
        op_a = 1'b0; op_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_token(input string req, input int base,
                               input int exp_sum, input int exp_carry, input int exp_fault);
        int hi = base + DELTA + 1;
        chk(req, "sum time",    first_hit(0, base, hi) - base, exp_sum);
        chk(req, "sum count",   n_hits(0, base, hi), 1);
        chk(req, "carry time",  first_hit(1, base, hi) - base, exp_carry);
        chk(req, "carry count", n_hits(1, base, hi), 1);
        chk(req, "fault count", n_hits(2, base, hi), exp_fault);
        if (exp_fault != 0) chk(req, "fault time", first_hit(2, base, hi) - base, DELTA + 1);
    endtask

    task automatic t_reset();
        chk("R1", "sum in reset", int'(sum_spk), 0);
        chk("R1", "carry in reset", int'(carry_spk), 0);
        chk("R1", "fault in reset", int'(fault), 0);
        @(negedge clk); rst_n = 1'b1;
        clear_seq();
        play(12);
        chk("R1", "quiet idle", n_hits(0, 0, 11) + n_hits(1, 0, 11) + n_hits(2, 0, 11), 0);
    endtask

    task automatic t_both_same();  // R2 R3: 1 + 1
        clear_seq();
        a_sp[0] = 1'b1; b_sp[0] = 1'b1;
        play(DELTA + 4);
        check_token("R2", 0, DELTA, WC, 0);
    endtask

    task automatic t_both_stagger();  // R3: B on last early offset
        clear_seq();
        a_sp[0] = 1'b1; b_sp[WC - 1] = 1'b1;
        play(DELTA + 4);
        check_token("R3", 0, DELTA, WC, 0);
    endtask

    task automatic t_one_early();  // R4: A=1, B=0
        clear_seq();
        a_sp[0] = 1'b1; b_sp[WC + GUARD + 1] = 1'b1;
        play(DELTA + 4);
        check_token("R4", 0, WC, DELTA, 0);
    endtask

    task automatic t_guard();  // R5: A lands on first guard offset
        clear_seq();
        b_sp[0] = 1'b1; a_sp[WC] = 1'b1;
        play(DELTA + 4);
        check_token("R5", 0, WC, DELTA, 0);
    endtask

    task automatic t_last_offset();  // R5 R6: late pulse on offset DELTA still belongs
        clear_seq();
        a_sp[0] = 1'b1; b_sp[DELTA] = 1'b1;
        play(DELTA + 4);
        check_token("R6", 0, WC, DELTA, 0);
    endtask

    task automatic t_missing();  // R8
        clear_seq();
        a_sp[0] = 1'b1;
        play(DELTA + 4);
        check_token("R8", 0, WC, DELTA, 1);
    endtask

    task automatic t_dup();  // R7: repeated B within window must not look like A early
        clear_seq();
        b_sp[0] = 1'b1; b_sp[1] = 1'b1; a_sp[WC + GUARD] = 1'b1;
        play(DELTA + 4);
        check_token("R7", 0, WC, DELTA, 1);
    endtask

    task automatic t_back_to_back();  // R9
        int t1 = DELTA + 1;
        clear_seq();
        a_sp[0] = 1'b1; b_sp[0] = 1'b1;
        a_sp[t1] = 1'b1; b_sp[t1 + WC + 1] = 1'b1;
        play(2 * (DELTA + 1) + 4);
        chk("R9", "tok1 carry", first_hit(1, 0, DELTA), WC);
        chk("R9", "tok1 sum",   first_hit(0, 0, DELTA), DELTA);
        check_token("R9", t1, WC, DELTA, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        clear_seq();
        repeat (3) @(negedge clk);
        t_reset();
        t_both_same();
        t_both_stagger();
        t_one_early();
        t_guard();
        t_last_offset();
        t_missing();
        t_dup();
        t_back_to_back();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule